// File: doc/BRIEF.md
# Stack-Protection Control Register Access Checker

This block owns two 64-bit stack-protection control registers, one for privilege level 1 and one for privilege level 2. It judges every system-register read or write aimed at them. Each request carries the current privilege level, the five encoding fields, a direction flag and write data. It also carries status: whether levels 2 and 3 exist, the three nested-virtualisation bits, host mode, the level-3 feature enable, the fine-grained-trap controls and two undefined-priority flags.

A fixed priority chain, keyed on privilege level, produces one outcome per request: completed, undefined, trap to level 2, trap to level 3, redirect to memory, or miss (the encoding names neither register). The chain also yields the trap syndrome class. A response state machine with two states, `ST_IDLE` and `ST_RESP`, returns the registered result. `ST_IDLE` moves to `ST_RESP` when a request is accepted. `ST_RESP` stays put while requests keep arriving and returns to `ST_IDLE` when none is present. A completed write updates the selected register at the same edge that captures the response.

Outcome codes on `rsp_kind`: 0 completed, 1 undefined, 2 trap to level 2, 3 trap to level 3, 4 redirect to memory, 5 miss.

Top module: `stkctl_access_unit`

## Requirements
- R1: A request hits when op0=3, CRn=2, CRm=5 and op2=0. With a hit, op1=4 selects the level-2 register and op1=0 selects the level-1 register. Any other encoding gives outcome 5 (miss) and changes no register.
- R2: A hit from privilege level 0 gives outcome 1 (undefined).
- R3: At level 1, an access to the level-2 register gives outcome 2 when nested-virtualisation bit 0 is 1 and level 2 exists. Otherwise it gives outcome 1.
- R4: Call the level-3 block condition "level 3 exists and its feature enable is 0". At level 2, and at level 1 for the level-1 register, this condition gives outcome 1 when `undef_prio` is set. If `undef_prio` is clear, it gives outcome 1 when `undef_sec` is set and outcome 3 when `undef_sec` is clear.
- R5: At level 1 for the level-1 register, the fine-grained trap is tested after the `undef_prio` case and before the rest of R4. It gives outcome 2 when all of these hold: level 2 exists, `fgt_present` is 1, level 3 is absent or `fgt_el3_en` is 1, and the negated trap bit for the request direction (`fgt_rd_n` for reads, `fgt_wr_n` for writes) is 0.
- R6: At level 1, for the level-1 register, with no earlier outcome, all three nested-virtualisation bits set and level 2 present, the outcome is 4. `rsp_mem_off` is then 0x8D0 and no register changes. For any other outcome `rsp_mem_off` is 0.
- R7: At level 2 in host mode, the level-1 encoding reads and writes the level-2 register.
- R8: Any hit from level 3 gives outcome 0 against the register that op1 selects.
- R9: Without level 2, a read of the level-2 register returns zero and a write to it is ignored.
- R10: Only bits 0, 5, 6, 8 and 9 of each register are stored (mask 0x361). All other bits read as zero.
- R11: Each accepted request yields `rsp_valid` exactly one clock later, and no request means no `rsp_valid`. A write changes a register only when the outcome is 0.
- R12: After reset both registers read as zero and `rsp_valid` is 0.
- R13: `rsp_ec` is 0x18 for outcomes 2 and 3 and 0 otherwise. `rsp_rdata` is zero unless the outcome is 0 on a read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present this cycle |
| req_el | input | 2 | Current privilege level |
| req_op0 | input | 2 | Encoding field op0 |
| req_op1 | input | 3 | Encoding field op1 |
| req_crn | input | 4 | Encoding field CRn |
| req_crm | input | 4 | Encoding field CRm |
| req_op2 | input | 3 | Encoding field op2 |
| req_write | input | 1 | 1 write, 0 read |
| req_wdata | input | 64 | Write data |
| have_el2 | input | 1 | Level 2 present and enabled |
| have_el3 | input | 1 | Level 3 present |
| nv_bits | input | 3 | Nested-virtualisation bits |
| host_mode | input | 1 | Level 2 runs as host |
| el3_feat_en | input | 1 | Level-3 enable for the feature |
| fgt_present | input | 1 | Fine-grained trap feature present |
| fgt_el3_en | input | 1 | Level-3 enable for fine-grained traps |
| fgt_rd_n | input | 1 | Negated fine-grained read trap bit |
| fgt_wr_n | input | 1 | Negated fine-grained write trap bit |
| undef_prio | input | 1 | Priority undefined flag |
| undef_sec | input | 1 | Secondary undefined flag |
| rsp_valid | output | 1 | Response present |
| rsp_kind | output | 3 | Outcome code |
| rsp_ec | output | 6 | Trap syndrome class |
| rsp_rdata | output | 64 | Read data |
| rsp_mem_off | output | 12 | Memory offset for a redirect |

## Verification
Every result of this block becomes visible one clock edge after the request: the outcome, the syndrome class, the memory offset and the read data. A register update from a write is visible to the request that follows it. The bench drives each request on a falling edge, lets one rising edge capture it, and samples the response one nanosecond after that edge. Register contents are checked through later level-3 reads, so each write is judged by the next read's data. Corner cases such as reserved bits, a missing level 2 and the ordering of the fine-grained trap against the level-3 checks are driven directly. Seeded random requests cover the rest of the chain.

// File: rtl/stkctl_pkg.sv
package stkctl_pkg;
    localparam int DATA_W   = 64;
    localparam int EC_W     = 6;
    localparam int OFF_W    = 12;
    localparam int KIND_W   = 3;
    localparam int NREG     = 2;

    localparam logic [DATA_W-1:0] FIELD_MASK = 64'h0000_0000_0000_0361;
    localparam logic [EC_W-1:0]   TRAP_EC    = 6'h18;
    localparam logic [OFF_W-1:0]  REDIR_OFF  = 12'h8D0;

    localparam logic [1:0] ENC_OP0 = 2'b11;
    localparam logic [3:0] ENC_CRN = 4'b0010;
    localparam logic [3:0] ENC_CRM = 4'b0101;
    localparam logic [2:0] ENC_OP2 = 3'b000;
    localparam logic [2:0] OP1_LV1 = 3'b000;
    localparam logic [2:0] OP1_LV2 = 3'b100;

    typedef enum logic [KIND_W-1:0] {
        K_DONE  = 3'd0,
        K_UNDEF = 3'd1,
        K_TRAP2 = 3'd2,
        K_TRAP3 = 3'd3,
        K_REDIR = 3'd4,
        K_MISS  = 3'd5
    } kind_e;

    typedef enum logic [1:0] {
        T_NONE = 2'd0,
        T_LV1  = 2'd1,
        T_LV2  = 2'd2
    } tgt_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RESP = 1'b1
    } state_e;
endpackage

// File: rtl/stkctl_decode.sv
module stkctl_decode
    import stkctl_pkg::*;
(
    input  logic [1:0] op0,
    input  logic [2:0] op1,
    input  logic [3:0] crn,
    input  logic [3:0] crm,
    input  logic [2:0] op2,
    output logic       hit_lv1,
    output logic       hit_lv2
);
    logic common_ok;

    always_comb begin
        common_ok = (op0 == ENC_OP0) && (crn == ENC_CRN) &&
                    (crm == ENC_CRM) && (op2 == ENC_OP2);
        hit_lv1   = common_ok && (op1 == OP1_LV1);
        hit_lv2   = common_ok && (op1 == OP1_LV2);
    end
endmodule

// File: rtl/stkctl_chain.sv
module stkctl_chain
    import stkctl_pkg::*;
(
    input  logic [1:0]      el,
    input  logic            is_wr,
    input  logic            hit_lv1,
    input  logic            hit_lv2,
    input  logic            have_el2,
    input  logic            have_el3,
    input  logic [2:0]      nv_bits,
    input  logic            host_mode,
    input  logic            el3_feat_en,
    input  logic            fgt_present,
    input  logic            fgt_el3_en,
    input  logic            fgt_rd_n,
    input  logic            fgt_wr_n,
    input  logic            undef_prio,
    input  logic            undef_sec,
    output kind_e           kind,
    output tgt_e            tgt,
    output logic [EC_W-1:0] ec
);
    logic [2:0] nv_eff;
    logic       host_eff;
    logic       lv3_block;
    logic       fgt_hit;
    logic       neg_bit;

    always_comb begin
        nv_eff    = have_el2 ? nv_bits : 3'b000;
        host_eff  = have_el2 && host_mode;
        lv3_block = have_el3 && !el3_feat_en;
        neg_bit   = is_wr ? fgt_wr_n : fgt_rd_n;
        fgt_hit   = have_el2 && fgt_present && (!have_el3 || fgt_el3_en) && !neg_bit;
    end

    always_comb begin
        kind = K_MISS;
        tgt  = T_NONE;
        if (hit_lv1 || hit_lv2) begin
            unique case (el)
                2'd0: kind = K_UNDEF;
                2'd1: begin
                    if (hit_lv2) begin
                        kind = nv_eff[0] ? K_TRAP2 : K_UNDEF;
                    end else if (lv3_block && undef_prio) begin
                        kind = K_UNDEF;
                    end else if (fgt_hit) begin
                        kind = K_TRAP2;
                    end else if (lv3_block) begin
                        kind = undef_sec ? K_UNDEF : K_TRAP3;
                    end else if (nv_eff == 3'b111) begin
                        kind = K_REDIR;
                    end else begin
                        kind = K_DONE;
                        tgt  = T_LV1;
                    end
                end
                2'd2: begin
                    if (lv3_block && undef_prio) begin
                        kind = K_UNDEF;
                    end else if (lv3_block) begin
                        kind = undef_sec ? K_UNDEF : K_TRAP3;
                    end else begin
                        kind = K_DONE;
                        tgt  = (hit_lv2 || host_eff) ? T_LV2 : T_LV1;
                    end
                end
                2'd3: begin
                    kind = K_DONE;
                    tgt  = hit_lv2 ? T_LV2 : T_LV1;
                end
            endcase
        end
        ec = ((kind == K_TRAP2) || (kind == K_TRAP3)) ? TRAP_EC : '0;
    end
endmodule

// File: rtl/stkctl_regbank.sv
module stkctl_regbank
    import stkctl_pkg::*;
#(
    parameter int                W    = DATA_W,
    parameter logic [DATA_W-1:0] MASK = FIELD_MASK
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_en,
    input  tgt_e         tgt,
    input  logic [W-1:0] wdata,
    input  logic         have_el2,
    output logic [W-1:0] rdata
);
    localparam logic [W-1:0] KEEP = MASK[W-1:0];

    logic [W-1:0] regs [NREG];

    for (genvar g = 0; g < NREG; g++) begin : g_reg
        logic wen;
        assign wen = wr_en && (tgt == tgt_e'(g + 1)) && ((g == 0) || have_el2);
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                regs[g] <= '0;
            end else if (wen) begin
                regs[g] <= wdata & KEEP;
            end
        end
    end

    always_comb begin
        unique case (tgt)
            T_LV1:   rdata = regs[0];
            T_LV2:   rdata = have_el2 ? regs[1] : '0;
            default: rdata = '0;
        endcase
    end
endmodule

// File: rtl/stkctl_access_unit.sv
module stkctl_access_unit
    import stkctl_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [1:0]        req_el,
    input  logic [1:0]        req_op0,
    input  logic [2:0]        req_op1,
    input  logic [3:0]        req_crn,
    input  logic [3:0]        req_crm,
    input  logic [2:0]        req_op2,
    input  logic              req_write,
    input  logic [63:0]       req_wdata,
    input  logic              have_el2,
    input  logic              have_el3,
    input  logic [2:0]        nv_bits,
    input  logic              host_mode,
    input  logic              el3_feat_en,
    input  logic              fgt_present,
    input  logic              fgt_el3_en,
    input  logic              fgt_rd_n,
    input  logic              fgt_wr_n,
    input  logic              undef_prio,
    input  logic              undef_sec,
    output logic              rsp_valid,
    output logic [2:0]        rsp_kind,
    output logic [5:0]        rsp_ec,
    output logic [63:0]       rsp_rdata,
    output logic [11:0]       rsp_mem_off
);
    state_e            state_q, state_d;
    logic              hit_lv1, hit_lv2;
    kind_e             kind;
    tgt_e              tgt;
    logic [EC_W-1:0]   ec;
    logic [DATA_W-1:0] bank_rdata;
    logic              bank_wr;

    stkctl_decode u_decode (
        .op0     (req_op0),
        .op1     (req_op1),
        .crn     (req_crn),
        .crm     (req_crm),
        .op2     (req_op2),
        .hit_lv1 (hit_lv1),
        .hit_lv2 (hit_lv2)
    );

    stkctl_chain u_chain (
        .el          (req_el),
        .is_wr       (req_write),
        .hit_lv1     (hit_lv1),
        .hit_lv2     (hit_lv2),
        .have_el2    (have_el2),
        .have_el3    (have_el3),
        .nv_bits     (nv_bits),
        .host_mode   (host_mode),
        .el3_feat_en (el3_feat_en),
        .fgt_present (fgt_present),
        .fgt_el3_en  (fgt_el3_en),
        .fgt_rd_n    (fgt_rd_n),
        .fgt_wr_n    (fgt_wr_n),
        .undef_prio  (undef_prio),
        .undef_sec   (undef_sec),
        .kind        (kind),
        .tgt         (tgt),
        .ec          (ec)
    );

    assign bank_wr = req_valid && req_write && (kind == K_DONE);

    stkctl_regbank u_bank (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (bank_wr),
        .tgt      (tgt),
        .wdata    (req_wdata),
        .have_el2 (have_el2),
        .rdata    (bank_rdata)
    );

    always_comb begin
        unique case (state_q)
            ST_IDLE: state_d = req_valid ? ST_RESP : ST_IDLE;
            ST_RESP: state_d = req_valid ? ST_RESP : ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rsp_kind    <= K_MISS;
            rsp_ec      <= '0;
            rsp_rdata   <= '0;
            rsp_mem_off <= '0;
        end else if (req_valid) begin
            rsp_kind    <= kind;
            rsp_ec      <= ec;
            rsp_rdata   <= ((kind == K_DONE) && !req_write) ? bank_rdata : '0;
            rsp_mem_off <= (kind == K_REDIR) ? REDIR_OFF : '0;
        end
    end

    assign rsp_valid = (state_q == ST_RESP);
endmodule

// File: rtl/stkctl_access_unit_chk.sv
module stkctl_access_unit_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        req_valid,
    input logic [1:0]  req_el,
    input logic [1:0]  req_op0,
    input logic [2:0]  req_op1,
    input logic [3:0]  req_crn,
    input logic [3:0]  req_crm,
    input logic [2:0]  req_op2,
    input logic        rsp_valid,
    input logic [2:0]  rsp_kind,
    input logic [5:0]  rsp_ec,
    input logic [63:0] rsp_rdata,
    input logic [11:0] rsp_mem_off
);
    logic enc_ok;
    assign enc_ok = (req_op0 == 2'b11) && (req_crn == 4'b0010) &&
                    (req_crm == 4'b0101) && (req_op2 == 3'b000) &&
                    ((req_op1 == 3'b000) || (req_op1 == 3'b100));

    // R11
    resp_follows_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);

    // R11
    no_spurious_resp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_valid);

    // R2
    lv0_undef_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && enc_ok && req_el == 2'd0) |=> (rsp_kind == 3'd1));

    // R8
    lv3_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && enc_ok && req_el == 2'd3) |=> (rsp_kind == 3'd0));

    // R1
    miss_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !enc_ok) |=> (rsp_kind == 3'd5));

    // R13
    ec_class_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> (rsp_ec == (((rsp_kind == 3'd2) || (rsp_kind == 3'd3)) ? 6'h18 : 6'h00)));

    // R6
    redir_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> (rsp_mem_off == ((rsp_kind == 3'd4) ? 12'h8D0 : 12'h000)));

    // R10
    reserved_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> ((rsp_rdata & ~64'h361) == 64'd0));

    // R13
    rdata_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_kind != 3'd0) |-> (rsp_rdata == 64'd0));
endmodule

bind stkctl_access_unit stkctl_access_unit_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_valid   (req_valid),
    .req_el      (req_el),
    .req_op0     (req_op0),
    .req_op1     (req_op1),
    .req_crn     (req_crn),
    .req_crm     (req_crm),
    .req_op2     (req_op2),
    .rsp_valid   (rsp_valid),
    .rsp_kind    (rsp_kind),
    .rsp_ec      (rsp_ec),
    .rsp_rdata   (rsp_rdata),
    .rsp_mem_off (rsp_mem_off)
);

// File: tb/test_stkctl_access_unit.sv
module test_stkctl_access_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [1:0]  req_el = '0;
    logic [1:0]  req_op0 = '0;
    logic [2:0]  req_op1 = '0;
    logic [3:0]  req_crn = '0;
    logic [3:0]  req_crm = '0;
    logic [2:0]  req_op2 = '0;
    logic        req_write = 1'b0;
    logic [63:0] req_wdata = '0;
    logic        have_el2 = 1'b1, have_el3 = 1'b1;
    logic [2:0]  nv_bits = '0;
    logic        host_mode = 1'b0, el3_feat_en = 1'b1;
    logic        fgt_present = 1'b0, fgt_el3_en = 1'b0;
    logic        fgt_rd_n = 1'b1, fgt_wr_n = 1'b1;
    logic        undef_prio = 1'b0, undef_sec = 1'b0;
    logic        rsp_valid;
    logic [2:0]  rsp_kind;
    logic [5:0]  rsp_ec;
    logic [63:0] rsp_rdata;
    logic [11:0] rsp_mem_off;

    int checks = 0;
    int errors = 0;
    logic [63:0] m_lv1 = '0, m_lv2 = '0;
    int e_kind, e_tgt;

    always #5 clk = ~clk;

    stkctl_access_unit i_stkctl_access_unit (.*);

    task automatic chk(input logic ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Bench model of the priority chain; sets e_kind (0..5) and e_tgt (0 none, 1 lv1, 2 lv2).
    function automatic void model(input logic [1:0] el, input logic [2:0] op1, input logic [1:0] op0,
                                  input logic [3:0] crn, input logic [3:0] crm, input logic [2:0] op2,
                                  input logic wr);
        logic hit, is2, blk, fg;
        logic [2:0] nv;
        hit = op0 == 2'b11 && crn == 4'd2 && crm == 4'd5 && op2 == 3'd0 && (op1 == 3'd0 || op1 == 3'd4);
        is2 = op1 == 3'd4;
        nv  = have_el2 ? nv_bits : 3'd0;
        blk = have_el3 && !el3_feat_en;
        fg  = have_el2 && fgt_present && (!have_el3 || fgt_el3_en) && ((wr ? fgt_wr_n : fgt_rd_n) == 1'b0);
        e_tgt = 0;
        if (!hit) e_kind = 5;
        else if (el == 0) e_kind = 1;
        else if (el == 3) begin e_kind = 0; e_tgt = is2 ? 2 : 1; end
        else if (el == 1 && is2) e_kind = nv[0] ? 2 : 1;
        else if (blk && undef_prio) e_kind = 1;
        else if (el == 1 && fg) e_kind = 2;
        else if (blk) e_kind = undef_sec ? 1 : 3;
        else if (el == 1 && nv == 3'b111) e_kind = 4;
        else if (el == 1) begin e_kind = 0; e_tgt = 1; end
        else begin e_kind = 0; e_tgt = (is2 || (have_el2 && host_mode)) ? 2 : 1; end
    endfunction

    task automatic access(input logic [1:0] el, input logic [2:0] op1, input logic wr,
                          input logic [63:0] wd, input string tag,
                          input logic [1:0] op0 = 2'b11, input logic [3:0] crn = 4'd2,
                          input logic [3:0] crm = 4'd5, input logic [2:0] op2 = 3'd0);
        logic [63:0] e_rd;
        @(negedge clk);
        req_valid = 1'b1; req_el = el; req_op1 = op1; req_write = wr; req_wdata = wd;
        req_op0 = op0; req_crn = crn; req_crm = crm; req_op2 = op2;
        model(el, op1, op0, crn, crm, op2, wr);
        e_rd = '0;
        if (e_kind == 0 && !wr) e_rd = (e_tgt == 1) ? m_lv1 : (have_el2 ? m_lv2 : 64'd0);
        if (e_kind == 0 && wr) begin
            if (e_tgt == 1) m_lv1 = wd & 64'h361;
            else if (have_el2) m_lv2 = wd & 64'h361;
        end
        @(posedge clk); #1;
        chk(rsp_valid == 1'b1, {tag, " R11 valid"}, 64'(rsp_valid), 64'd1);
        chk(rsp_kind == 3'(e_kind), {tag, " kind"}, 64'(rsp_kind), 64'(e_kind));
        chk(rsp_ec == ((e_kind == 2 || e_kind == 3) ? 6'h18 : 6'h0), {tag, " R13 ec"}, 64'(rsp_ec), 64'(e_kind));
        chk(rsp_rdata == e_rd, {tag, " rdata"}, rsp_rdata, e_rd);
        chk(rsp_mem_off == ((e_kind == 4) ? 12'h8D0 : 12'h0), {tag, " R6 off"}, 64'(rsp_mem_off), 64'(e_kind));
    endtask

    task automatic idle_cycle();
        @(negedge clk); req_valid = 1'b0;
        @(posedge clk); #1;
        chk(rsp_valid == 1'b0, "R11 idle no resp", 64'(rsp_valid), 64'd0);
    endtask

    initial begin
        #300000;
        errors++; checks++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        void'($urandom(32'h1234_5678));
        repeat (3) @(posedge clk);
        #1;
        chk(rsp_valid == 1'b0, "R12 valid in reset", 64'(rsp_valid), 64'd0);
        rst_n = 1'b1;
        // R12 reset contents
        access(2'd3, 3'd0, 1'b0, '0, "R12 lv1 after reset");
        access(2'd3, 3'd4, 1'b0, '0, "R12 lv2 after reset");
        // R10 mask, R8 level-3 direct
        access(2'd3, 3'd4, 1'b1, 64'hFFFF_FFFF_FFFF_FFFF, "R10 R8 write lv2 ones");
        access(2'd3, 3'd4, 1'b0, '0, "R10 read lv2 masked");
        access(2'd3, 3'd0, 1'b1, 64'h0000_0000_0000_0121, "R8 write lv1");
        access(2'd3, 3'd0, 1'b0, '0, "R8 read lv1");
        // R1 miss, no write
        access(2'd3, 3'd1, 1'b1, '0, "R1 miss op1");
        access(2'd3, 3'd0, 1'b1, '0, "R1 miss crm", 2'b11, 4'd2, 4'd6, 3'd0);
        access(2'd3, 3'd0, 1'b0, '0, "R1 lv1 unchanged");
        // R2
        access(2'd0, 3'd0, 1'b1, '0, "R2 lv0 write");
        access(2'd0, 3'd4, 1'b0, '0, "R2 lv0 read");
        // R3
        nv_bits = 3'b001;
        access(2'd1, 3'd4, 1'b0, '0, "R3 nv0 trap");
        nv_bits = 3'b110;
        access(2'd1, 3'd4, 1'b1, '0, "R3 undef");
        // R6 redirect, no write
        nv_bits = 3'b111;
        access(2'd1, 3'd0, 1'b1, 64'h361, "R6 redirect");
        nv_bits = 3'b000;
        access(2'd3, 3'd0, 1'b0, '0, "R6 lv1 untouched");
        // R4 level-3 block chain
        el3_feat_en = 1'b0; undef_prio = 1'b1;
        access(2'd2, 3'd4, 1'b0, '0, "R4 prio undef");
        undef_prio = 1'b0; undef_sec = 1'b1;
        access(2'd2, 3'd0, 1'b0, '0, "R4 sec undef");
        undef_sec = 1'b0;
        access(2'd1, 3'd0, 1'b1, '0, "R4 trap lv3");
        // R5 ordering: fgt wins over level-3 trap, loses to prio undef
        fgt_present = 1'b1; fgt_el3_en = 1'b1; fgt_wr_n = 1'b0;
        access(2'd1, 3'd0, 1'b1, '0, "R5 fgt before lv3");
        access(2'd1, 3'd0, 1'b0, '0, "R5 read uses rd bit");
        undef_prio = 1'b1;
        access(2'd1, 3'd0, 1'b1, '0, "R5 prio first");
        undef_prio = 1'b0; el3_feat_en = 1'b1; fgt_el3_en = 1'b0;
        access(2'd1, 3'd0, 1'b1, 64'h1, "R5 el3 gate off");
        fgt_present = 1'b0; fgt_wr_n = 1'b1;
        // R7 host mode
        host_mode = 1'b1;
        access(2'd2, 3'd0, 1'b1, 64'h240, "R7 host write");
        access(2'd3, 3'd4, 1'b0, '0, "R7 lv2 got it");
        access(2'd3, 3'd0, 1'b0, '0, "R7 lv1 kept");
        host_mode = 1'b0;
        access(2'd2, 3'd0, 1'b1, 64'h20, "R7 non-host lv1");
        // R9 no level 2
        have_el2 = 1'b0;
        access(2'd3, 3'd4, 1'b0, '0, "R9 read zero");
        access(2'd3, 3'd4, 1'b1, 64'h1, "R9 write ignored");
        have_el2 = 1'b1;
        access(2'd3, 3'd4, 1'b0, '0, "R9 lv2 preserved");
        idle_cycle();
        // Random mix
        for (int i = 0; i < 600; i++) begin
            logic [1:0] el, op0;
            logic [2:0] op1;
            logic [3:0] crm;
            logic [63:0] wd;
            el  = 2'($urandom_range(0, 3));
            op1 = ($urandom_range(0, 9) == 0) ? 3'($urandom) : (($urandom_range(0, 1) == 1) ? 3'd4 : 3'd0);
            op0 = ($urandom_range(0, 19) == 0) ? 2'b10 : 2'b11;
            crm = ($urandom_range(0, 19) == 0) ? 4'd4 : 4'd5;
            wd  = {$urandom, $urandom};
            have_el2 = ($urandom_range(0, 7) != 0);
            have_el3 = 1'($urandom);
            nv_bits = 3'($urandom);
            host_mode = 1'($urandom);
            el3_feat_en = ($urandom_range(0, 2) != 0);
            fgt_present = 1'($urandom);
            fgt_el3_en = 1'($urandom);
            fgt_rd_n = 1'($urandom);
            fgt_wr_n = 1'($urandom);
            undef_prio = 1'($urandom);
            undef_sec = 1'($urandom);
            access(el, op1, 1'($urandom), wd, "R4 R5 random", op0, 4'd2, crm, 3'd0);
            if ($urandom_range(0, 15) == 0) idle_cycle();
        end
        have_el2 = 1'b1;
        access(2'd3, 3'd0, 1'b0, '0, "R10 final lv1");
        access(2'd3, 3'd4, 1'b0, '0, "R10 final lv2");
        idle_cycle();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule